// File: doc/BRIEF.md
# Programmable Delayed Frame Sync Generator

This block derives a delayed, active-high frame sync for an auxiliary time-division port from a reference frame sync. Everything runs in the data-clock domain. Each rising edge of the reference sync restarts a delay counter. When that counter reaches a programmed 10-bit delay, the block emits a pulse. The pulse width comes from a small menu of 1, 2, 8 or 16 clocks.

The pulse drives the external sync pin. It is also qualified into a one-cycle frame-start strobe that the auxiliary port uses as its own frame reference, so the port's slot timing matches devices that follow the pin.

The delay and width settings are captured only when a reference frame starts. An enable input blanks both outputs.

Top module: `dfsync_gen`

## Requirements
- R1: After reset, and until the first rising edge of `refFs` is sampled, `syncOut` and `frameStart` are low.
- R2: The first clock edge that samples `refFs` high, after a sample of `refFs` low, is the frame start edge E0. With a captured delay d, `syncOut` goes high right after edge E(d+1). The delay is set in steps of one data clock.
- R3: Every delay from 0 up to 1023 (0x3FF) is honoured, including the maximum.
- R4: The captured width select sets the pulse length in data clocks: 2'b00 gives 1, 2'b01 gives 2, 2'b10 gives 8, 2'b11 gives 16.
- R5: At most one pulse is produced per frame. A `refFs` level held high for several clocks starts only one frame.
- R6: A new frame start edge clears an active pulse at that edge and restarts the delay count from zero.
- R7: `delayCfg` and `widthSel` are captured only at a frame start edge. Changes made later in the frame do not move or resize the pulse of that frame.
- R8: While `enable` is low, `syncOut` and `frameStart` are low. A pulse is cleared at any edge that samples `enable` low. A pulse starts only if `enable` is sampled high at edge E(d+1); a missed start is not retried in that frame.
- R9: `frameStart` is high for exactly the first clock of each `syncOut` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dcl | input | 1 | Data clock; all state changes on its rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| refFs | input | 1 | Reference frame sync, active high |
| delayCfg | input | 10 | Delay from frame start, in data clocks |
| widthSel | input | 2 | Pulse width select (1/2/8/16 clocks) |
| enable | input | 1 | Output enable; low blanks both outputs |
| syncOut | output | 1 | Delayed frame sync pin, active high |
| frameStart | output | 1 | One-cycle strobe for the auxiliary port's frame reference |

## Verification
The assertions assume that `refFs` is low while reset is held. They also assume that `enable` and the reference sync change only between clock edges, so a sampled rise of `refFs` is a true frame start. The bench drives every input on the falling clock edge and holds `refFs` low through reset.

The bench always drops `refFs` for at least one clock before the next frame. This keeps each frame start a distinct sampled rise. Random frame lengths are sometimes shorter than the programmed delay, which exercises the restart and cut-short behaviour inside those rules.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
  localparam int DELAY_W = 10;
  localparam int WSEL_W  = 2;
  localparam int RUN_W   = 4;   // holds longest pulse length minus one

  // Strobes from control into the datapath
  typedef struct packed {
    logic restart;    // frame start: clear counter, capture settings
    logic loadWidth;  // pulse begins: load remaining-width counter
    logic tickWidth;  // pulse running: count width down
  } dpStrobe_t;

  // Pulse length minus one for each width code
  function automatic logic [RUN_W-1:0] widthLenM1(input logic [WSEL_W-1:0] sel);
    logic [RUN_W-1:0] len;
    case (sel)
      2'b00:   len = RUN_W'(0);
      2'b01:   len = RUN_W'(1);
      2'b10:   len = RUN_W'(7);
      default: len = RUN_W'(15);
    endcase
    return len;
  endfunction
endpackage

// File: rtl/fsync_datapath.sv
module fsync_datapath
  import fsync_pkg::*;
#(
  parameter int CNT_W = DELAY_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [CNT_W-1:0]  delayCfg,
  input  logic [WSEL_W-1:0] widthSel,
  output logic              match,
  output logic              widthDone
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0]  delayCnt;
  logic [CNT_W-1:0]  delayQ;
  logic [WSEL_W-1:0] widthQ;
  logic [RUN_W-1:0]  widthLeft;

  // Delay counter and shadow copies of the settings
  always_ff @(posedge clk) begin
    if (!rstN) begin
      delayCnt <= '0;
      delayQ   <= '0;
      widthQ   <= '0;
    end else if (strb.restart) begin
      delayCnt <= '0;
      delayQ   <= delayCfg;
      widthQ   <= widthSel;
    end else if (delayCnt != CNT_MAX) begin
      delayCnt <= delayCnt + 1'b1;
    end
  end

  // Remaining pulse width
  always_ff @(posedge clk) begin
    if (!rstN) begin
      widthLeft <= '0;
    end else if (strb.restart) begin
      widthLeft <= '0;
    end else if (strb.loadWidth) begin
      widthLeft <= widthLenM1(widthQ);
    end else if (strb.tickWidth) begin
      widthLeft <= widthLeft - 1'b1;
    end
  end

  assign match     = (delayCnt == delayQ);
  assign widthDone = (widthLeft == '0);
endmodule

// File: rtl/fsync_control.sv
module fsync_control
  import fsync_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      refFs,
  input  logic      enable,
  input  logic      match,
  input  logic      widthDone,
  output dpStrobe_t strb,
  output logic      pulseOn,
  output logic      startOn
);
  logic refQ;
  logic refRise;
  logic armed;
  logic fire;

  assign refRise = refFs & ~refQ;
  assign fire    = armed & match & enable & ~refRise;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refQ    <= 1'b0;
      armed   <= 1'b0;
      pulseOn <= 1'b0;
      startOn <= 1'b0;
    end else begin
      refQ    <= refFs;
      startOn <= fire;
      // Arm on frame start; disarm once the delay point has passed
      if (refRise)             armed <= 1'b1;
      else if (armed && match) armed <= 1'b0;
      // Pulse state
      if (refRise || !enable)       pulseOn <= 1'b0;
      else if (fire)                pulseOn <= 1'b1;
      else if (pulseOn && widthDone) pulseOn <= 1'b0;
    end
  end

  always_comb begin
    strb.restart   = refRise;
    strb.loadWidth = fire;
    strb.tickWidth = pulseOn & ~widthDone;
  end
endmodule

// File: rtl/dfsync_gen.sv
module dfsync_gen
  import fsync_pkg::*;
(
  input  logic               dcl,
  input  logic               rstN,
  input  logic               refFs,
  input  logic [DELAY_W-1:0] delayCfg,
  input  logic [WSEL_W-1:0]  widthSel,
  input  logic               enable,
  output logic               syncOut,
  output logic               frameStart
);
  dpStrobe_t strb;
  logic match;
  logic widthDone;
  logic pulseOn;
  logic startOn;

  fsync_control u_ctl (
    .clk       (dcl),
    .rstN      (rstN),
    .refFs     (refFs),
    .enable    (enable),
    .match     (match),
    .widthDone (widthDone),
    .strb      (strb),
    .pulseOn   (pulseOn),
    .startOn   (startOn)
  );

  fsync_datapath #(.CNT_W(DELAY_W)) u_dp (
    .clk       (dcl),
    .rstN      (rstN),
    .strb      (strb),
    .delayCfg  (delayCfg),
    .widthSel  (widthSel),
    .match     (match),
    .widthDone (widthDone)
  );

  assign syncOut    = pulseOn & enable;
  assign frameStart = startOn & enable;
endmodule

// File: rtl/dfsync_gen_chk.sv
module dfsync_gen_chk (
  input logic dcl,
  input logic rstN,
  input logic refFs,
  input logic enable,
  input logic syncOut,
  input logic frameStart
);
  logic [4:0] runLen;
  logic       seenRef;

  always_ff @(posedge dcl) begin
    if (!rstN) begin
      runLen  <= '0;
      seenRef <= 1'b0;
    end else begin
      runLen  <= syncOut ? ((runLen == 5'd31) ? runLen : runLen + 1'b1) : 5'd0;
      if (refFs) seenRef <= 1'b1;
    end
  end

  // R1
  no_early_pulse_chk: assert property (@(posedge dcl) disable iff (!rstN)
    !seenRef |-> !syncOut);
  // R4
  max_width_chk: assert property (@(posedge dcl) disable iff (!rstN)
    syncOut |-> runLen < 5'd16);
  // R6
  cut_on_restart_chk: assert property (@(posedge dcl) disable iff (!rstN)
    $rose(refFs) |=> !syncOut);
  // R8
  enable_blank_chk: assert property (@(posedge dcl) disable iff (!rstN)
    !enable |-> (!syncOut && !frameStart));
  // R9
  strobe_in_pulse_chk: assert property (@(posedge dcl) disable iff (!rstN)
    frameStart |-> syncOut);
  // R9
  strobe_single_chk: assert property (@(posedge dcl) disable iff (!rstN)
    frameStart |=> !frameStart);
  // R9
  strobe_at_rise_chk: assert property (@(posedge dcl) disable iff (!rstN)
    $rose(syncOut) |-> frameStart);
endmodule

bind dfsync_gen dfsync_gen_chk u_chk (
  .dcl        (dcl),
  .rstN       (rstN),
  .refFs      (refFs),
  .enable     (enable),
  .syncOut    (syncOut),
  .frameStart (frameStart)
);

// File: tb/tb_dfsync_gen.sv
`timescale 1ns/1ps
module tb_dfsync_gen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refFs = 1'b0;
  logic [9:0] delayCfg = '0;
  logic [1:0] widthSel = '0;
  logic       enable = 1'b1;
  logic       syncOut;
  logic       frameStart;

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #4 clk = ~clk;

  dfsync_gen dut (
    .dcl(clk), .rstN(rstN), .refFs(refFs), .delayCfg(delayCfg),
    .widthSel(widthSel), .enable(enable), .syncOut(syncOut), .frameStart(frameStart)
  );

  function automatic int widthOf(input logic [1:0] s);
    case (s)
      2'b00: return 1;
      2'b01: return 2;
      2'b10: return 8;
      default: return 16;
    endcase
  endfunction

  // Frame-relative expectation built from the requirements
  int  edgeN = 0, riseN = 0, mDel = 0, mW = 1, pStart = -1;
  bit  prevRef = 0, waitFire = 0;
  bit  expSync = 0, expStart = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      edgeN = 0; prevRef = 0; waitFire = 0; pStart = -1;
    end else begin
      edgeN++;
      if (refFs && !prevRef) begin
        riseN = edgeN; mDel = delayCfg; mW = widthOf(widthSel);
        waitFire = 1; pStart = -1;
      end else begin
        if (waitFire && edgeN == riseN + mDel + 1) begin
          waitFire = 0;
          if (enable) pStart = edgeN;
        end
        if (!enable) pStart = -1;
      end
      prevRef = refFs;
    end
    expSync  = (pStart >= 0) && (edgeN - pStart < mW);
    expStart = (pStart >= 0) && (edgeN == pStart);
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  // Wait to the falling edge, compare, then caller drives the next inputs
  task automatic cyc();
    @(negedge clk);
    check(tag, syncOut, expSync && enable);
    check("R9", frameStart, expStart && enable);
  endtask

  task automatic frame(input int d, input int w, input int len, input int hold);
    delayCfg = 10'(d); widthSel = 2'(w); refFs = 1'b1;
    repeat (hold) cyc();
    refFs = 1'b0;
    repeat (len - hold) cyc();
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog t=%0t actual=running expected=finished", $time);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state and quiet time before any reference
    tag = "R1";
    repeat (4) cyc();
    rstN = 1'b1;
    delayCfg = 10'd0;
    repeat (20) cyc();

    // R2: several small delays, single-clock width
    tag = "R2";
    frame(0, 0, 12, 1);
    frame(1, 0, 12, 1);
    frame(5, 0, 14, 2);
    frame(9, 1, 20, 1);

    // R4: every width code
    tag = "R4";
    for (int w = 0; w < 4; w++) frame(3, w, 30, 1);

    // R3: maximum delay
    tag = "R3";
    frame(1023, 2, 1045, 1);

    // R5: long reference level starts one frame only
    tag = "R5";
    frame(2, 0, 60, 50);

    // R6: new frame cuts a 16-clock pulse short
    tag = "R6";
    frame(2, 3, 7, 1);
    frame(0, 3, 30, 1);

    // R7: settings changed mid-frame are ignored until next start
    tag = "R7";
    delayCfg = 10'd10; widthSel = 2'd0; refFs = 1'b1;
    cyc(); refFs = 1'b0; cyc(); cyc();
    delayCfg = 10'd3; widthSel = 2'd3;
    repeat (30) cyc();
    frame(3, 3, 30, 1);

    // R8: enable low at the delay point, then dropped mid-pulse
    tag = "R8";
    enable = 1'b0; delayCfg = 10'd4; widthSel = 2'd2; refFs = 1'b1;
    cyc(); refFs = 1'b0; repeat (8) cyc();
    enable = 1'b1; repeat (20) cyc();
    frame(2, 3, 6, 1);
    enable = 1'b0; repeat (3) cyc();
    enable = 1'b1; repeat (20) cyc();

    // Random frames with mid-frame setting changes and enable dropouts
    tag = "R2";
    for (int f = 0; f < 250; f++) begin
      int len  = 10 + int'($urandom_range(140));
      int hold = 1 + int'($urandom_range(2));
      delayCfg = 10'($urandom_range(len + 10));
      widthSel = 2'($urandom_range(3));
      refFs = 1'b1;
      for (int c = 0; c < len; c++) begin
        cyc();
        if (c + 1 >= hold) refFs = 1'b0;
        if ($urandom_range(19) == 0) delayCfg = 10'($urandom_range(1023));
        if ($urandom_range(19) == 0) widthSel = 2'($urandom_range(3));
        if ($urandom_range(39) == 0) enable = ~enable;
      end
      enable = 1'b1;
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule